// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 32K words by 8 bits. The host gives single-beat requests through a request/ready handshake: an address, write data and a write flag. Reads come back as a byte with a one-cycle valid pulse. On the memory side the controller drives the address bus and the active-low chip, write and output enables. The bidirectional 8-bit data bus is split into an output value, an output enable and an input, and the pad ring joins them.

Every strobe width and gap is a whole number of clock cycles. Each count is worked out at elaboration from a clock-period parameter and the memory's timing figures in picoseconds. The count is rounded up and is never less than one. A write is the overlap of chip enable and write enable. Both strobes fall together and rise together, and the data is held across the edge that ends the overlap. After a read, the controller leaves a turnaround gap so the memory's outputs can float before the controller drives the bus again.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and whenever the controller is idle, ready_o is 1, mem_ce_no, mem_we_no and mem_oe_no are all 1, and mem_dq_oe_o is 0.
- R2: A request is accepted on a rising edge where req_i and ready_o are both 1. Address, data and write flag are captured at that edge. ready_o is 0 from then until the controller is idle again, and req_i is ignored while ready_o is 0.
- R3: A read (write flag 0) drives the captured address for one lead cycle with all strobes high. It then holds mem_ce_no and mem_oe_no at 0 and mem_we_no at 1 for N_RD = max(ceil(t_aa/clk), ceil(t_doe/clk)) cycles.
- R4: mem_dq_i is sampled at the edge that ends the read window. rdata_o then carries it and rvalid_o is 1 for exactly one cycle, starting N_RD+1 cycles after the acceptance edge.
- R5: A write (write flag 1) drives the address and data with mem_dq_oe_o = 1 for one lead cycle with all strobes high. It then holds mem_ce_no and mem_we_no at 0 together for N_WP = ceil(t_sce/clk) cycles, and both rise on the same edge. mem_oe_no stays 1 for the whole write.
- R6: After the write strobes rise, mem_dq_o and mem_dq_oe_o = 1 are held unchanged for one more cycle, and then the bus is released.
- R7: mem_addr_o does not change while mem_ce_no is 0.
- R8: mem_dq_oe_o is never 1 while mem_oe_no is 0. After mem_oe_no rises, the bus stays undriven for more than N_HZOE = ceil(t_hzoe/clk) cycles.
- R9: ready_o returns max(N_RC, 1+N_RD+N_HZOE) cycles after the acceptance edge of a read, and max(N_RC, N_WP+3) cycles after that of a write, where N_RC = ceil(t_rc/clk).
- R10: Every count is rounded up and is at least 1. With the clock period at least as long as every timing figure, a read gives rvalid_o 2 cycles after acceptance and a write holds mem_we_no low for 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| ready_o | output | 1 | Controller idle, request will be taken |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (15) | Host word address |
| wdata_i | input | DATA_W (8) | Host write data |
| rdata_o | output | DATA_W (8) | Read data |
| rvalid_o | output | 1 | One-cycle pulse, rdata_o valid |
| mem_addr_o | output | ADDR_W (15) | Memory address bus |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W (8) | Data bus value driven to memory |
| mem_dq_oe_o | output | 1 | Data bus output enable |
| mem_dq_i | input | DATA_W (8) | Data bus value from memory |

## Verification
The assertions assume that reset is held low across at least one clock edge. They also assume that the memory model drives mem_dq_i only while mem_ce_no and mem_oe_no are low and mem_we_no is high. The stimulus keeps to both assumptions. Reset is held for several cycles, and the bench memory places a fixed filler pattern on mem_dq_i outside a read, so a wrong sample time shows up as bad data. Requests are changed on the falling edge, often while the controller is busy, so that the hold of captured values is tested. A second instance with default timing covers the rounding floor.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RD_ACC,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RECOV
  } seq_state_e;

  // cycles needed to cover t_ps, never below one
  function automatic int unsigned cyc_ceil(int unsigned t_ps, int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_req_capture.sv
module sram_req_capture #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] wdata_q_o,
  output logic              wr_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o  <= '0;
      wdata_q_o <= '0;
      wr_q_o    <= 1'b0;
    end else if (load_i) begin
      addr_q_o  <= addr_i;
      wdata_q_o <= wdata_i;
      wr_q_o    <= wr_i;
    end
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned N_RD   = 1,
  parameter int unsigned N_WP   = 1,
  parameter int unsigned N_HZOE = 1,
  parameter int unsigned N_RC   = 1,
  parameter int unsigned CNT_W  = 2,
  parameter int unsigned RC_W   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic wr_i,
  input  logic wr_q_i,
  output logic ready_o,
  output logic accept_o,
  output logic sample_o,
  output logic ce_n_o,
  output logic we_n_o,
  output logic oe_n_o,
  output logic drive_o
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] HZ_LOAD = CNT_W'(N_HZOE - 1);
  localparam logic [RC_W-1:0]  RC_LIM  = RC_W'(N_RC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RC_W-1:0]  cyc_q;
  logic             cyc_ok;
  logic             drive_d;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o && req_i;
  assign sample_o = (state_q == ST_RD_ACC) && (cnt_q == '0);
  assign cyc_ok   = (cyc_q >= RC_LIM);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_LEAD;
      ST_LEAD: begin
        if (wr_q_i) begin
          state_d = ST_WR_PULSE;
          cnt_d   = WP_LOAD;
        end else begin
          state_d = ST_RD_ACC;
          cnt_d   = RD_LOAD;
        end
      end
      ST_RD_ACC: begin
        if (cnt_q == '0) begin
          state_d = ST_RECOV;
          cnt_d   = HZ_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WR_PULSE: begin
        if (cnt_q == '0) state_d = ST_WR_HOLD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_WR_HOLD: begin
        state_d = ST_RECOV;
        cnt_d   = '0;
      end
      ST_RECOV: begin
        if (cnt_q == '0) begin
          if (cyc_ok) state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // bus is driven in the write lead cycle only when the accepted request is a write
  assign drive_d = ((state_d == ST_LEAD) && wr_i) ||
                   (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ce_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      drive_o <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ce_n_o  <= !((state_d == ST_RD_ACC) || (state_d == ST_WR_PULSE));
      we_n_o  <= !(state_d == ST_WR_PULSE);
      oe_n_o  <= !(state_d == ST_RD_ACC);
      drive_o <= drive_d;
    end
  end

  // cycles since acceptance, saturating at the cycle-time limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cyc_q <= RC_LIM;
    else if (accept_o)                    cyc_q <= '0;
    else if (!ready_o && (cyc_q < RC_LIM)) cyc_q <= cyc_q + 1'b1;
  end

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              drive_i,
  input  logic              sample_i,
  input  logic [DATA_W-1:0] wdata_q_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  assign mem_dq_o    = wdata_q_i;
  assign mem_dq_oe_o = drive_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= sample_i;
      if (sample_i) rdata_o <= mem_dq_i;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_PS = 20000,
  parameter int unsigned T_RC_PS       = 10000,
  parameter int unsigned T_AA_PS       = 10000,
  parameter int unsigned T_DOE_PS      = 5000,
  parameter int unsigned T_SCE_PS      = 8000,
  parameter int unsigned T_HZOE_PS     = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              ready_o,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned N_RD   = max2(cyc_ceil(T_AA_PS, CLK_PERIOD_PS),
                                        cyc_ceil(T_DOE_PS, CLK_PERIOD_PS));
  localparam int unsigned N_WP   = cyc_ceil(T_SCE_PS, CLK_PERIOD_PS);
  localparam int unsigned N_HZOE = cyc_ceil(T_HZOE_PS, CLK_PERIOD_PS);
  localparam int unsigned N_RC   = cyc_ceil(T_RC_PS, CLK_PERIOD_PS);
  localparam int unsigned N_MAX  = max2(max2(N_RD, N_WP), N_HZOE);
  localparam int unsigned CNT_W  = $clog2(N_MAX + 1);
  localparam int unsigned RC_W   = $clog2(N_RC + 1);

  logic              accept;
  logic              sample;
  logic              drive;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;

  sram_req_capture #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .wr_i      (wr_i),
    .addr_q_o  (mem_addr_o),
    .wdata_q_o (wdata_q),
    .wr_q_o    (wr_q)
  );

  sram_seq_fsm #(
    .N_RD   (N_RD),
    .N_WP   (N_WP),
    .N_HZOE (N_HZOE),
    .N_RC   (N_RC),
    .CNT_W  (CNT_W),
    .RC_W   (RC_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .wr_i     (wr_i),
    .wr_q_i   (wr_q),
    .ready_o  (ready_o),
    .accept_o (accept),
    .sample_o (sample),
    .ce_n_o   (mem_ce_no),
    .we_n_o   (mem_we_no),
    .oe_n_o   (mem_oe_no),
    .drive_o  (drive)
  );

  sram_dq_path #(
    .DATA_W (DATA_W)
  ) u_dq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drive_i     (drive),
    .sample_i    (sample),
    .wdata_q_i   (wdata_q),
    .mem_dq_i    (mem_dq_i),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_HZOE = 1,
  parameter int unsigned N_RC   = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);

  localparam int unsigned HZ_W = $clog2(N_HZOE + 1);
  localparam int unsigned RC_W = $clog2(N_RC + 1);
  localparam logic [HZ_W-1:0] HZ_SAT = HZ_W'(N_HZOE);
  localparam logic [RC_W-1:0] RC_SAT = RC_W'(N_RC);

  logic [HZ_W-1:0] oe_gap_q;
  logic [RC_W-1:0] since_acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  oe_gap_q <= HZ_SAT;
    else if (!mem_oe_no)          oe_gap_q <= '0;
    else if (oe_gap_q < HZ_SAT)   oe_gap_q <= oe_gap_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     since_acc_q <= RC_SAT;
    else if (req_i && ready_o)       since_acc_q <= '0;
    else if (since_acc_q < RC_SAT)   since_acc_q <= since_acc_q + 1'b1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_ce_no && mem_we_no && mem_oe_no && !mem_dq_oe_o));

  p_acc_spacing_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |-> (since_acc_q >= RC_SAT));

  p_rd_no_we_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (mem_we_no && !mem_ce_no));

  p_rvalid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  p_we_in_ce_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_ce_no);

  p_data_lead_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> $past(mem_dq_oe_o));

  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (mem_dq_oe_o && $stable(mem_dq_o)));

  p_addr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> $stable(mem_addr_o));

  p_turnaround_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (mem_oe_no && (oe_gap_q >= HZ_SAT)));

endmodule

bind sram_async_ctrl sram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .N_HZOE (N_HZOE),
  .N_RC   (N_RC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ce_no   (mem_ce_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_dq_o    (mem_dq_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

  // clock period stated to the controller is shortened so the counts exceed one
  localparam int N_RD   = 4;   // max(ceil(10000/2500), ceil(5000/2500))
  localparam int N_WP   = 4;   // ceil(8000/2500)
  localparam int N_HZOE = 5;   // ceil(12500/2500)
  localparam int N_RC   = 8;   // ceil(20000/2500)
  localparam logic [7:0] FILL = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic        req = 1'b0, wr = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rvalid, ce_n, we_n, oe_n, dq_oe;
  logic [7:0]  rdata, dq_o;
  logic [7:0]  dq_i = FILL;
  logic [14:0] maddr;

  sram_async_ctrl #(
    .CLK_PERIOD_PS (2500),
    .T_RC_PS       (20000),
    .T_AA_PS       (10000),
    .T_DOE_PS      (5000),
    .T_SCE_PS      (8000),
    .T_HZOE_PS     (12500)
  ) u_sram_async_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .ready_o (ready), .wr_i (wr),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .rvalid_o (rvalid),
    .mem_addr_o (maddr), .mem_ce_no (ce_n), .mem_we_no (we_n), .mem_oe_no (oe_n),
    .mem_dq_o (dq_o), .mem_dq_oe_o (dq_oe), .mem_dq_i (dq_i)
  );

  // second instance with default timing, every count at its floor of one
  logic        d_req = 1'b0, d_wr = 1'b0;
  logic        d_ready, d_rvalid, d_ce_n, d_we_n, d_oe_n, d_dq_oe;
  logic [7:0]  d_rdata, d_dq_o;
  logic [14:0] d_maddr;

  sram_async_ctrl u_sram_async_ctrl_dflt (
    .clk_i (clk), .rst_ni (rst_n), .req_i (d_req), .ready_o (d_ready), .wr_i (d_wr),
    .addr_i (15'h0005), .wdata_i (8'hC3), .rdata_o (d_rdata), .rvalid_o (d_rvalid),
    .mem_addr_o (d_maddr), .mem_ce_no (d_ce_n), .mem_we_no (d_we_n), .mem_oe_no (d_oe_n),
    .mem_dq_o (d_dq_o), .mem_dq_oe_o (d_dq_oe), .mem_dq_i (8'h3C)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on every rising edge
  bit          m_busy = 0;
  bit          m_wr   = 0;
  int          m_t    = 0;
  int          m_end  = 0;
  logic [14:0] m_addr = '0;
  logic [7:0]  m_wdata = '0;
  logic [7:0]  exp_mem [int];
  logic [7:0]  ram [int];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0;
      m_t    = 0;
    end else if (m_busy) begin
      m_t++;
      if (m_t >= m_end) m_busy = 0;
    end else if (req) begin
      m_busy  = 1;
      m_t     = 0;
      m_wr    = wr;
      m_addr  = addr;
      m_wdata = wdata;
      m_end   = wr ? ((N_RC > N_WP + 3) ? N_RC : N_WP + 3)
                   : ((N_RC > 1 + N_RD + N_HZOE) ? N_RC : 1 + N_RD + N_HZOE);
      if (wr) exp_mem[int'(addr)] = wdata;
    end
  end

  // memory model and per-cycle comparison, both on the falling edge
  bit          pend_wr = 0;
  logic [14:0] pend_addr = '0;
  int          oe_hi = 100;
  logic [7:0]  exp_rd;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(ready && ce_n && we_n && oe_n && !dq_oe, "R1 reset idle", {ready, ce_n, we_n, oe_n, dq_oe}, 5'b11110);
    end else begin
      chk(ready == !m_busy, "R2/R9 ready", ready, !m_busy);
      chk(ce_n == !(m_busy && m_t >= 1 && m_t <= (m_wr ? N_WP : N_RD)), "R3/R5 ce_n", ce_n,
          !(m_busy && m_t >= 1 && m_t <= (m_wr ? N_WP : N_RD)));
      chk(oe_n == !(m_busy && !m_wr && m_t >= 1 && m_t <= N_RD), "R3/R5 oe_n", oe_n,
          !(m_busy && !m_wr && m_t >= 1 && m_t <= N_RD));
      chk(we_n == !(m_busy && m_wr && m_t >= 1 && m_t <= N_WP), "R5 we_n", we_n,
          !(m_busy && m_wr && m_t >= 1 && m_t <= N_WP));
      chk(dq_oe == (m_busy && m_wr && m_t <= N_WP + 1), "R5/R6 dq_oe", dq_oe,
          m_busy && m_wr && m_t <= N_WP + 1);
      if (m_busy) chk(maddr == m_addr, "R2/R7 addr", maddr, m_addr);
      if (dq_oe) chk(dq_o == m_wdata, "R6 dq data", dq_o, m_wdata);
      chk(rvalid == (m_busy && !m_wr && m_t == N_RD + 1), "R4 rvalid", rvalid,
          m_busy && !m_wr && m_t == N_RD + 1);
      if (rvalid) begin
        exp_rd = exp_mem.exists(int'(m_addr)) ? exp_mem[int'(m_addr)] : 8'h00;
        chk(rdata === exp_rd, "R4 rdata", rdata, exp_rd);
      end
      // R8: turnaround after a read
      if (!oe_n) oe_hi = 0; else if (oe_hi < 100) oe_hi++;
      if (dq_oe) chk(oe_n && oe_hi > N_HZOE, "R8 turnaround", oe_hi, N_HZOE + 1);
    end
    // commit a write when the overlap of chip and write enable has ended
    if (!ce_n && !we_n) begin
      pend_wr   = 1;
      pend_addr = maddr;
    end else if (pend_wr) begin
      pend_wr = 0;
      ram[int'(pend_addr)] = dq_oe ? dq_o : 8'hxx;
    end
    if (!ce_n && !oe_n && we_n)
      dq_i <= ram.exists(int'(maddr)) ? ram[int'(maddr)] : 8'h00;
    else
      dq_i <= FILL;
  end

  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int we_low;
  initial begin : stim
    repeat (4) @(negedge clk);
    rst_n = 1;
    // directed writes and read-back at the address extremes
    issue(1, 15'h0000, 8'h11);
    issue(1, 15'h7FFF, 8'hEE);
    issue(1, 15'h1234, 8'h9C);
    issue(0, 15'h7FFF, 8'h00);
    issue(0, 15'h0000, 8'h00);
    issue(0, 15'h1234, 8'h00);
    issue(0, 15'h0042, 8'h00);   // never written
    // request held high, inputs changing every cycle, many ignored while busy
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      req   = ($urandom % 4) != 0;
      wr    = $urandom % 2;
      addr  = {12'h0A5, 3'($urandom)};
      wdata = 8'($urandom);
    end
    @(negedge clk);
    req = 0;
    while (!ready) @(negedge clk);
    // R10: default timing, counts at their floor
    d_wr = 0; d_req = 1;
    @(negedge clk); d_req = 0;              // after acceptance edge
    chk(!d_rvalid, "R10 rvalid t1", d_rvalid, 0);
    @(negedge clk);
    chk(!d_rvalid && !d_oe_n, "R10 read strobe", {d_rvalid, d_oe_n}, 0);
    @(negedge clk);
    chk(d_rvalid && d_rdata == 8'h3C, "R10 rvalid t2", {d_rvalid, d_rdata}, {1'b1, 8'h3C});
    @(negedge clk);
    chk(d_ready, "R10 read ready", d_ready, 1);
    d_wr = 1; d_req = 1;
    @(negedge clk); d_req = 0;
    we_low = 0;
    for (int i = 0; i < 6; i++) begin
      if (!d_we_n) we_low++;
      @(negedge clk);
    end
    chk(we_low == 1, "R10 write pulse", we_low, 1);
    chk(d_ready, "R10 write ready", d_ready, 1);
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule